// File: doc/BRIEF.md
# Radio Transceiver State Sequencer

This block is the control sequencer of a radio transceiver. It brings the transceiver up from first power-on, puts it to sleep and wakes it, ramps the analog supply and synthesiser on command, and runs the transmit burst. Each of these is a fixed series of steps. Every step that waits on analog settling is gated by a countdown of a 1 MHz tick enable, so the timer lengths are in microseconds. The analog blocks appear only as enable outputs. Commands arrive as one-cycle codes from a serial front end that is outside this block.

The states are: power-on (code 0x00, first counting the oscillator timer and then holding), SLEEP (0x0F), the transitional wake steps (oscillator start, stabilisation, filter tuning), TRX_OFF (0x08), the analog-regulator ramp, PLL_ON (0x09), RX_ON (0x06), the transmit burst (0x02, made of synthesiser settling, amplifier ramp and frame), and the receive-settling turnaround. Every transitional step reports code 0x1F. The transitions are:

- power-on → hold, when the oscillator timer expires;
- hold → TRX_OFF, on the TRX_OFF command;
- TRX_OFF → SLEEP, when the sleep pin is high;
- SLEEP → oscillator start, when the sleep pin goes low;
- oscillator start → stabilisation → filter tuning → TRX_OFF, each when its timer expires;
- TRX_OFF → ramp, on the PLL_ON or RX_ON command;
- ramp → the requested mode, when the ramp timer expires;
- PLL_ON ↔ RX_ON, on the matching command;
- PLL_ON or RX_ON → TRX_OFF, on the TRX_OFF command;
- PLL_ON → burst, on a rising sleep pin;
- burst → PLL_ON, or burst → turnaround → RX_ON, when the frame ends;
- any state → filter tuning, while chip reset is low.

Top module: `radio_seq`

## Requirements
- R1: While `por_i` is high and after it falls, `state_o` is 0x00 with enables 0x07. After T_XOSC ticks, `clk_stable_irq_o` pulses for one cycle. The state then stays at 0x00 until a TRX_OFF command, which moves it to 0x08.
- R2: Command codes on `cmd_i` are 0 none, 1 TRX_OFF, 2 PLL_ON, 3 RX_ON, each valid for one cycle. A command that is not legal in the current state (for example PLL_ON in the power-on hold or in SLEEP) leaves state and enables unchanged.
- R3: In TRX_OFF, with no command present, a high `slp_tr_i` moves the state to SLEEP (0x0F), where all enables are 0.
- R4: In SLEEP, a low `slp_tr_i` starts the wake series. It runs T_XOSC ticks with enables 0x01, then `clk_stable_irq_o` pulses. It then runs T_STAB ticks with enables 0x07, then T_FTN ticks with enables 0x0F, and ends in TRX_OFF.
- R5: A PLL_ON or RX_ON command in TRX_OFF enables the analog regulator (enables 0x17) for T_AREG ticks. The state then becomes the requested mode with enables 0x37.
- R6: In PLL_ON, an RX_ON command gives RX_ON on the next cycle whatever the level of `pll_lock_i`. In RX_ON, a PLL_ON command gives PLL_ON. From either mode, TRX_OFF returns to 0x08.
- R7: A rising `slp_tr_i` in PLL_ON enters BUSY_TX (0x02). The block runs T_TXPLL ticks with enables 0x37, then T_PA ticks with enables 0x77. `tx_start_o` then pulses for one cycle and the frame lasts T_FRAME ticks.
- R8: At frame end the state returns to PLL_ON. If RX_ON was commanded during the burst, the block instead spends T_RXPLL ticks at 0x1F with enables 0x37 and then enters RX_ON.
- R9: A low `rst_n_i` forces the filter-tuning step (0x1F, enables 0x0F) from any state and holds it there. After release, T_FTN ticks lead to TRX_OFF.
- R10: `pll_lock_irq_o` pulses for one cycle, one cycle after each rising edge of `pll_lock_i`.
- R11: Every transitional step (ramp, wake steps, filter tuning, receive turnaround) reports `state_o` = 0x1F.

Enable bit positions in `blk_en_o`: [0] oscillator, [1] band-gap, [2] digital regulator, [3] filter tuning, [4] analog regulator, [5] PLL, [6] power amplifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on flag, active high, asynchronous reset to power-on |
| tick_i | input | 1 | 1 MHz tick enable, one clock wide |
| rst_n_i | input | 1 | Chip reset, active low, synchronous |
| slp_tr_i | input | 1 | Sleep / transmit-start pin |
| pll_lock_i | input | 1 | Synthesiser lock indication |
| cmd_i | input | 2 | Command strobe: 0 none, 1 TRX_OFF, 2 PLL_ON, 3 RX_ON |
| state_o | output | 5 | Current state code |
| blk_en_o | output | 7 | Analog block enables |
| clk_stable_irq_o | output | 1 | Oscillator-timer expiry pulse |
| pll_lock_irq_o | output | 1 | Lock rising-edge pulse |
| tx_start_o | output | 1 | Frame-start strobe |

## Verification
Every output is registered, so the result of an input, command or final tick shows one clock after the edge that samples it. A timed step ends on the edge that samples its last tick, and the three pulse outputs rise together with that state change. The bench steps a behavioural model on each rising edge from the same inputs. It compares every output at the following falling edge, so each result is checked in the cycle it is due. The tick enable is gapped, so timer lengths are counted in ticks and not in cycles.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

    typedef enum logic [3:0] {
        S_PON_OSC, S_PON_WAIT, S_SLEEP, S_WAKE_OSC, S_WAKE_STAB, S_FTN,
        S_TRX_OFF, S_RAMP, S_PLL_ON, S_RX_ON, S_TX_PLL, S_TX_PA,
        S_TX_FRAME, S_TX2RX
    } seq_state_e;

    localparam logic [1:0] CMD_NONE    = 2'd0;
    localparam logic [1:0] CMD_TRX_OFF = 2'd1;
    localparam logic [1:0] CMD_PLL_ON  = 2'd2;
    localparam logic [1:0] CMD_RX_ON   = 2'd3;

    localparam logic [4:0] CODE_P_ON    = 5'h00;
    localparam logic [4:0] CODE_TRX_OFF = 5'h08;
    localparam logic [4:0] CODE_PLL_ON  = 5'h09;
    localparam logic [4:0] CODE_RX_ON   = 5'h06;
    localparam logic [4:0] CODE_BUSY_TX = 5'h02;
    localparam logic [4:0] CODE_SLEEP   = 5'h0F;
    localparam logic [4:0] CODE_TRANS   = 5'h1F;

    localparam int EN_W  = 7;
    localparam int EN_PA = 6;
    localparam int EN_PLL = 5;
    localparam int EN_AREG = 4;
    localparam logic [EN_W-1:0] M_OFF  = 7'h00;
    localparam logic [EN_W-1:0] M_XOSC = 7'h01;
    localparam logic [EN_W-1:0] M_CORE = 7'h07;
    localparam logic [EN_W-1:0] M_TUNE = 7'h0F;
    localparam logic [EN_W-1:0] M_RAMP = 7'h17;
    localparam logic [EN_W-1:0] M_SYN  = 7'h37;
    localparam logic [EN_W-1:0] M_PA   = 7'h77;

    function automatic logic [4:0] code_of(seq_state_e s);
        logic [4:0] c;
        case (s)
            S_PON_OSC, S_PON_WAIT:           c = CODE_P_ON;
            S_SLEEP:                         c = CODE_SLEEP;
            S_TRX_OFF:                       c = CODE_TRX_OFF;
            S_PLL_ON:                        c = CODE_PLL_ON;
            S_RX_ON:                         c = CODE_RX_ON;
            S_TX_PLL, S_TX_PA, S_TX_FRAME:   c = CODE_BUSY_TX;
            default:                         c = CODE_TRANS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W       = 9,
    parameter int RST_LEN = 128
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)
            cnt_q <= W'(RST_LEN);
        else if (load_i)
            cnt_q <= len_i;
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign done_o = tick_i && (cnt_q == W'(1));

    // R4: an expiring count never wraps to a large value on the next cycle
    p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (por_i)
        (done_o && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/seq_edge.sv
module seq_edge (
    input  logic clk_i,
    input  logic por_i,
    input  logic d_i,
    output logic rise_o
);
    logic d_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) d_q <= 1'b0;
        else       d_q <= d_i;
    end

    assign rise_o = d_i && !d_q;
endmodule

// File: rtl/radio_seq.sv
module radio_seq
    import radio_seq_pkg::*;
#(
    parameter int T_XOSC  = 128,
    parameter int T_STAB  = 256,
    parameter int T_FTN   = 25,
    parameter int T_AREG  = 16,
    parameter int T_TXPLL = 14,
    parameter int T_PA    = 2,
    parameter int T_FRAME = 100,
    parameter int T_RXPLL = 32
) (
    input  logic            clk_i,
    input  logic            por_i,
    input  logic            tick_i,
    input  logic            rst_n_i,
    input  logic            slp_tr_i,
    input  logic            pll_lock_i,
    input  logic [1:0]      cmd_i,
    output logic [4:0]      state_o,
    output logic [EN_W-1:0] blk_en_o,
    output logic            clk_stable_irq_o,
    output logic            pll_lock_irq_o,
    output logic            tx_start_o
);
    localparam int MAX_A = (T_XOSC > T_STAB) ? T_XOSC : T_STAB;
    localparam int MAX_B = (T_FTN > T_AREG) ? T_FTN : T_AREG;
    localparam int MAX_C = (T_TXPLL > T_PA) ? T_TXPLL : T_PA;
    localparam int MAX_D = (T_FRAME > T_RXPLL) ? T_FRAME : T_RXPLL;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
    localparam int MAX_L = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW = $clog2(MAX_L + 1);

    seq_state_e    st, nxt;
    logic          t_done, t_load;
    logic [TW-1:0] t_len;
    logic          slp_rise, lock_rise;
    logic          ramp_rx, rx_pend;
    logic          in_tx;

    function automatic logic [TW-1:0] len_of(seq_state_e s);
        logic [TW-1:0] l;
        case (s)
            S_PON_OSC, S_WAKE_OSC: l = TW'(T_XOSC);
            S_WAKE_STAB:           l = TW'(T_STAB);
            S_FTN:                 l = TW'(T_FTN);
            S_RAMP:                l = TW'(T_AREG);
            S_TX_PLL:              l = TW'(T_TXPLL);
            S_TX_PA:               l = TW'(T_PA);
            S_TX_FRAME:            l = TW'(T_FRAME);
            S_TX2RX:               l = TW'(T_RXPLL);
            default:               l = '0;
        endcase
        return l;
    endfunction

    seq_timer #(.W(TW), .RST_LEN(T_XOSC)) u_timer (
        .clk_i(clk_i), .por_i(por_i), .tick_i(tick_i),
        .load_i(t_load), .len_i(t_len), .done_o(t_done)
    );

    seq_edge u_slp_edge (.clk_i(clk_i), .por_i(por_i), .d_i(slp_tr_i), .rise_o(slp_rise));
    seq_edge u_lock_edge (.clk_i(clk_i), .por_i(por_i), .d_i(pll_lock_i), .rise_o(lock_rise));

    assign in_tx = (st == S_TX_PLL) || (st == S_TX_PA) || (st == S_TX_FRAME);

    // next-state logic
    always_comb begin
        nxt = st;
        if (!rst_n_i) begin
            nxt = S_FTN;
        end else begin
            unique case (st)
                S_PON_OSC:   if (t_done) nxt = S_PON_WAIT;
                S_PON_WAIT:  if (cmd_i == CMD_TRX_OFF) nxt = S_TRX_OFF;
                S_SLEEP:     if (!slp_tr_i) nxt = S_WAKE_OSC;
                S_WAKE_OSC:  if (t_done) nxt = S_WAKE_STAB;
                S_WAKE_STAB: if (t_done) nxt = S_FTN;
                S_FTN:       if (t_done) nxt = S_TRX_OFF;
                S_TRX_OFF: begin
                    if (cmd_i == CMD_PLL_ON || cmd_i == CMD_RX_ON) nxt = S_RAMP;
                    else if (cmd_i == CMD_NONE && slp_tr_i)          nxt = S_SLEEP;
                end
                S_RAMP:      if (t_done) nxt = ramp_rx ? S_RX_ON : S_PLL_ON;
                S_PLL_ON: begin
                    if (cmd_i == CMD_TRX_OFF)     nxt = S_TRX_OFF;
                    else if (cmd_i == CMD_RX_ON)  nxt = S_RX_ON;
                    else if (slp_rise)            nxt = S_TX_PLL;
                end
                S_RX_ON: begin
                    if (cmd_i == CMD_TRX_OFF)     nxt = S_TRX_OFF;
                    else if (cmd_i == CMD_PLL_ON) nxt = S_PLL_ON;
                end
                S_TX_PLL:    if (t_done) nxt = S_TX_PA;
                S_TX_PA:     if (t_done) nxt = S_TX_FRAME;
                S_TX_FRAME:  if (t_done) nxt = (rx_pend || cmd_i == CMD_RX_ON) ? S_TX2RX : S_PLL_ON;
                S_TX2RX:     if (t_done) nxt = S_RX_ON;
            endcase
        end
    end

    assign t_load = (nxt != st) || !rst_n_i;
    assign t_len  = len_of(nxt);

    // state register and sequencing flags
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            st               <= S_PON_OSC;
            ramp_rx          <= 1'b0;
            rx_pend          <= 1'b0;
            clk_stable_irq_o <= 1'b0;
            pll_lock_irq_o   <= 1'b0;
            tx_start_o       <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_TRX_OFF && cmd_i == CMD_RX_ON)       ramp_rx <= 1'b1;
            else if (st == S_TRX_OFF && cmd_i == CMD_PLL_ON) ramp_rx <= 1'b0;
            if (st == S_PLL_ON)                    rx_pend <= 1'b0;
            else if (in_tx && cmd_i == CMD_RX_ON)  rx_pend <= 1'b1;
            clk_stable_irq_o <= rst_n_i && t_done && (st == S_PON_OSC || st == S_WAKE_OSC);
            tx_start_o       <= rst_n_i && t_done && (st == S_TX_PA);
            pll_lock_irq_o   <= lock_rise;
        end
    end

    // outputs
    always_comb begin
        state_o = code_of(st);
        unique case (st)
            S_SLEEP:                            blk_en_o = M_OFF;
            S_WAKE_OSC:                         blk_en_o = M_XOSC;
            S_PON_OSC, S_PON_WAIT, S_WAKE_STAB,
            S_TRX_OFF:                          blk_en_o = M_CORE;
            S_FTN:                              blk_en_o = M_TUNE;
            S_RAMP:                             blk_en_o = M_RAMP;
            S_TX_PA, S_TX_FRAME:                blk_en_o = M_PA;
            default:                            blk_en_o = M_SYN;
        endcase
    end

    p_irq_single_r1: assert property (@(posedge clk_i) disable iff (por_i)
        clk_stable_irq_o |=> !clk_stable_irq_o);
    p_sleep_quiet_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (state_o == CODE_SLEEP) |-> (blk_en_o == M_OFF));
    p_pll_after_areg_r5: assert property (@(posedge clk_i) disable iff (por_i)
        blk_en_o[EN_PLL] |-> blk_en_o[EN_AREG]);
    p_rx_preempt_r6: assert property (@(posedge clk_i) disable iff (por_i)
        (st == S_PLL_ON && rst_n_i && cmd_i == CMD_RX_ON) |=> (state_o == CODE_RX_ON));
    p_pa_in_tx_r7: assert property (@(posedge clk_i) disable iff (por_i)
        blk_en_o[EN_PA] |-> (state_o == CODE_BUSY_TX));
    p_strobe_frame_r7: assert property (@(posedge clk_i) disable iff (por_i)
        tx_start_o |-> (st == S_TX_FRAME));
    p_reset_tune_r9: assert property (@(posedge clk_i) disable iff (por_i)
        !rst_n_i |=> (blk_en_o == M_TUNE));
    p_lock_irq_r10: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(pll_lock_i) |=> pll_lock_irq_o);
endmodule

// File: tb/tb_radio_seq.sv
module tb_radio_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LX = 5, LS = 7, LF = 3, LA = 4, LT = 3, LP = 2, LFR = 6, LR = 5;

    logic       clk = 0, por = 1, tick = 0, rst_n = 1, slp = 0, lock = 0;
    logic [1:0] cmd = 0;
    logic [4:0] state_o;
    logic [6:0] blk_en_o;
    logic       clk_irq, lock_irq, tx_start;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    radio_seq #(.T_XOSC(LX), .T_STAB(LS), .T_FTN(LF), .T_AREG(LA), .T_TXPLL(LT),
                .T_PA(LP), .T_FRAME(LFR), .T_RXPLL(LR)) dut (
        .clk_i(clk), .por_i(por), .tick_i(tick), .rst_n_i(rst_n), .slp_tr_i(slp),
        .pll_lock_i(lock), .cmd_i(cmd), .state_o(state_o), .blk_en_o(blk_en_o),
        .clk_stable_irq_o(clk_irq), .pll_lock_irq_o(lock_irq), .tx_start_o(tx_start));

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        cyc++;
        tick <= (cyc % 4) != 3;
    end

    // behavioural model: phases
    localparam int PO = 0, PW = 1, SL = 2, WO = 3, WS = 4, FT = 5, OFF = 6, RA = 7,
                   PL = 8, RX = 9, TP = 10, TA = 11, TF = 12, TR = 13;
    int m_ph, m_rem;
    bit m_rx, m_pend, m_slpq, m_lkq, m_cirq, m_lirq, m_txs;

    function automatic int mlen(int p);
        case (p)
            PO, WO: return LX;
            WS: return LS;
            FT: return LF;
            RA: return LA;
            TP: return LT;
            TA: return LP;
            TF: return LFR;
            TR: return LR;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] mcode(int p);
        case (p)
            PO, PW: return 5'h00;
            SL: return 5'h0F;
            OFF: return 5'h08;
            PL: return 5'h09;
            RX: return 5'h06;
            TP, TA, TF: return 5'h02;
            default: return 5'h1F;
        endcase
    endfunction

    function automatic logic [6:0] men(int p);
        case (p)
            SL: return 7'h00;
            WO: return 7'h01;
            PO, PW, WS, OFF: return 7'h07;
            FT: return 7'h0F;
            RA: return 7'h17;
            TA, TF: return 7'h77;
            default: return 7'h37;
        endcase
    endfunction

    function automatic string mreq(int p);
        case (p)
            PO, PW: return "R1";
            SL: return "R3";
            WO, WS: return "R4";
            FT: return "R9";
            OFF: return "R2";
            RA: return "R5";
            PL, RX: return "R6";
            TR: return "R8";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        int np;
        bit expd, rise, npend;
        if (por) begin
            m_ph = PO; m_rem = LX; m_rx = 0; m_pend = 0; m_slpq = 0; m_lkq = 0;
            m_cirq = 0; m_lirq = 0; m_txs = 0;
        end else begin
            expd = tick && (m_rem == 1);
            rise = slp && !m_slpq;
            np = m_ph;
            if (!rst_n) np = FT;
            else case (m_ph)
                PO: if (expd) np = PW;
                PW: if (cmd == 1) np = OFF;
                SL: if (!slp) np = WO;
                WO: if (expd) np = WS;
                WS: if (expd) np = FT;
                FT: if (expd) np = OFF;
                OFF: if (cmd == 2 || cmd == 3) np = RA; else if (cmd == 0 && slp) np = SL;
                RA: if (expd) np = m_rx ? RX : PL;
                PL: if (cmd == 1) np = OFF; else if (cmd == 3) np = RX; else if (rise) np = TP;
                RX: if (cmd == 1) np = OFF; else if (cmd == 2) np = PL;
                TP: if (expd) np = TA;
                TA: if (expd) np = TF;
                TF: if (expd) np = (m_pend || cmd == 3) ? TR : PL;
                TR: if (expd) np = RX;
                default: np = m_ph;
            endcase
            m_cirq = rst_n && expd && (m_ph == PO || m_ph == WO);
            m_txs  = rst_n && expd && (m_ph == TA);
            m_lirq = lock && !m_lkq;
            npend = m_pend;
            if (m_ph == PL) npend = 0;
            else if ((m_ph == TP || m_ph == TA || m_ph == TF) && cmd == 3) npend = 1;
            if (m_ph == OFF && cmd == 3) m_rx = 1;
            else if (m_ph == OFF && cmd == 2) m_rx = 0;
            m_pend = npend;
            if (np != m_ph || !rst_n) m_rem = mlen(np);
            else if (tick && m_rem > 0) m_rem--;
            m_ph = np;
            m_slpq = slp; m_lkq = lock;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!por && !finished) begin
            chk(state_o == mcode(m_ph), mreq(m_ph), state_o, mcode(m_ph));
            chk(blk_en_o == men(m_ph), mreq(m_ph), blk_en_o, men(m_ph));
            chk(clk_irq == m_cirq, "R1/R4 clk-stable", clk_irq, m_cirq);
            chk(lock_irq == m_lirq, "R10", lock_irq, m_lirq);
            chk(tx_start == m_txs, "R7 strobe", tx_start, m_txs);
        end
    end

    task automatic send(logic [1:0] c);
        @(negedge clk); cmd = c;
        @(negedge clk); cmd = 0;
    endtask

    task automatic wait_code(logic [4:0] c, string tag);
        for (int i = 0; i < 400; i++) begin
            if (state_o == c) break;
            @(negedge clk);
        end
        chk(state_o == c, tag, state_o, c);
    endtask

    task automatic wait_pulse(string which, string tag);
        bit seen = 0;
        for (int i = 0; i < 400; i++) begin
            if ((which == "clk" && clk_irq) || (which == "tx" && tx_start)) begin
                seen = 1; break;
            end
            @(negedge clk);
        end
        chk(seen, tag, seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por = 0;
        @(negedge clk);
        chk(state_o == 5'h00, "R1 reset", state_o, 5'h00);
        chk(blk_en_o == 7'h07, "R1 reset", blk_en_o, 7'h07);
        wait_pulse("clk", "R1 clk-stable");
        @(negedge clk);
        send(2'd2);
        chk(state_o == 5'h00, "R2 ignored", state_o, 5'h00);
        send(2'd1);
        chk(state_o == 5'h08, "R1 trx_off", state_o, 5'h08);
        // ramp to RX_ON
        send(2'd3);
        chk(state_o == 5'h1F, "R11 ramp", state_o, 5'h1F);
        chk(blk_en_o == 7'h17, "R5 ramp", blk_en_o, 7'h17);
        wait_code(5'h06, "R5 rx");
        chk(blk_en_o == 7'h37, "R5 pll", blk_en_o, 7'h37);
        send(2'd2);
        chk(state_o == 5'h09, "R6 pll", state_o, 5'h09);
        @(negedge clk); lock = 1;
        @(negedge clk);
        chk(lock_irq == 1, "R10 rise", lock_irq, 1);
        @(negedge clk);
        chk(lock_irq == 0, "R10 single", lock_irq, 0);
        lock = 0;
        send(2'd3);
        chk(state_o == 5'h06, "R6 preempt", state_o, 5'h06);
        send(2'd2);
        // burst with receive request
        @(negedge clk); slp = 1;
        @(negedge clk);
        chk(state_o == 5'h02, "R7 busy", state_o, 5'h02);
        send(2'd3);
        wait_pulse("tx", "R7 strobe");
        chk(blk_en_o == 7'h77, "R7 pa", blk_en_o, 7'h77);
        for (int i = 0; i < 400 && state_o == 5'h02; i++) @(negedge clk);
        chk(state_o == 5'h1F, "R8 turnaround", state_o, 5'h1F);
        wait_code(5'h06, "R8 rx");
        slp = 0;
        send(2'd2);
        // burst without request
        @(negedge clk); slp = 1;
        @(negedge clk);
        for (int i = 0; i < 400 && state_o == 5'h02; i++) @(negedge clk);
        chk(state_o == 5'h09, "R8 plain", state_o, 5'h09);
        slp = 0;
        send(2'd1);
        chk(state_o == 5'h08, "R6 off", state_o, 5'h08);
        // sleep and wake
        @(negedge clk); slp = 1;
        @(negedge clk);
        chk(state_o == 5'h0F, "R3 sleep", state_o, 5'h0F);
        send(2'd2);
        chk(blk_en_o == 7'h00, "R2 sleep ignored", blk_en_o, 7'h00);
        slp = 0;
        @(negedge clk);
        chk(blk_en_o == 7'h01, "R4 osc", blk_en_o, 7'h01);
        wait_pulse("clk", "R4 clk-stable");
        wait_code(5'h08, "R4 trx_off");
        // chip reset from RX_ON
        send(2'd3);
        wait_code(5'h06, "R5 rx");
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(blk_en_o == 7'h0F, "R9 tune", blk_en_o, 7'h0F);
        repeat (4) @(negedge clk);
        chk(state_o == 5'h1F, "R9 hold", state_o, 5'h1F);
        rst_n = 1;
        wait_code(5'h08, "R9 trx_off");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule